// File: doc/BRIEF.md
# ADC Threshold Monitor with Hysteresis

This block watches a stream of signed 16-bit converter samples. It raises a status flag soon enough for downstream gain control to react to the input level, without waiting for the signal to pass through the rest of the datapath. Each sample is reduced to a 14-bit magnitude. That magnitude is compared against an upper and a lower threshold. A dwell counter requires a run of consecutive low samples before a "too quiet" condition counts, so short excursions are filtered out.

There are two independent flag channels. Each channel has its own operating mode, its own thresholds, its own dwell count and its own clear input. The modes are:

- **Disabled**: the flag is held low.
- **Latch-high**: the flag latches when the level goes above the upper threshold.
- **Latch-low**: the flag latches after a long enough quiet run.
- **Band**: the flag sets above the upper threshold and drops by itself after a quiet run.

Configuration is written one field at a time through a small parallel write port.

Top module: `adc_level_watch`

## Requirements
- R1: The magnitude of a sample is its absolute value shifted right by one bit, giving 14 bits. The code -32768 saturates to 16383. For example, 32767 and 32766 both give 16383, -2 gives 1, and 1 gives 0.
- R2: In disabled mode (mode code 0), the channel flag is low at all times and sample input has no effect on it. After reset, every channel is in disabled mode with its flag low.
- R3: In latch-high mode (mode code 1), a valid sample whose magnitude is strictly greater than the upper threshold sets the flag at the next clock edge. The flag then stays high until a clear.
- R4: In latch-low mode (mode code 2), the flag sets once the dwell condition of R6 is met. It stays high until a clear, and a sample at or above the lower threshold does not drop it.
- R5: In band mode (mode code 3), a valid sample above the upper threshold sets the flag. The flag drops at the edge that meets the dwell condition of R6. Samples between the two thresholds leave it unchanged.
- R6: The dwell condition is met on a valid sample whose magnitude is strictly below the lower threshold and which is at least the Nth consecutive such valid sample, where N is the dwell count. N=0 and N=1 both fire on the first low sample. A valid sample at or above the lower threshold restarts the run. Cycles without a valid sample neither advance nor restart it.
- R7: A clear input drops its channel's flag at the next edge in any mode. If a set condition occurs in the same cycle, the set condition wins.
- R8: Writing a channel's mode field, even with an unchanged value, forces that channel's flag low and restarts its run at the next edge. This overrides any sample in that cycle.
- R9: The two channels are fully independent. Writes, clears and configuration of one channel never change the other channel's flag.
- R10: A configuration write selects its channel with `cfg_chan` and its field with `cfg_sel`:
  - 0 is the mode, in `cfg_data[1:0]`.
  - 1 is the upper threshold, in `cfg_data[13:0]`.
  - 2 is the lower threshold, in `cfg_data[13:0]`.
  - 3 is the dwell count, in `cfg_data[31:0]`.

  A threshold or dwell count written in a cycle applies to samples from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 16 | Signed two's-complement sample |
| clr | input | 2 | Per-channel flag clear |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chan | input | 1 | Channel addressed by the write |
| cfg_sel | input | 2 | Field addressed by the write |
| cfg_data | input | 32 | Write data |
| flag | output | 2 | Per-channel threshold flag |

## Verification
Directed sequences exercise the magnitude extremes: the most negative code, the largest positive code, and a threshold of 16383 that no sample can exceed. These separate a correct saturating magnitude from a plain shift or a sign error. Dwell runs are interrupted by samples at or above the lower threshold and by idle cycles, which tells a restarting counter apart from one that only pauses or that counts idle cycles. Band-mode runs mixed with mid-band samples check that the set and drop conditions are kept distinct. A long random mix then follows, with small thresholds and dwell counts, random clears and configuration writes colliding with samples. It checks the priority between set, clear and mode writes, and that the two channels stay independent.

// File: rtl/adc_level_watch.sv
module adc_level_watch #(
  parameter int NCH = 2,
  parameter int SW  = 16,
  parameter int TW  = 14,
  parameter int DW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid,
  input  logic [SW-1:0]  smp_data,
  input  logic [NCH-1:0] clr,
  input  logic           cfg_wr,
  input  logic [CW-1:0]  cfg_chan,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_data,
  output logic [NCH-1:0] flag
);
  localparam logic [1:0] M_OFF  = 2'd0;
  localparam logic [1:0] M_OVER = 2'd1;
  localparam logic [1:0] M_UNDR = 2'd2;
  localparam logic [1:0] M_HYST = 2'd3;

  logic [SW-1:0] abs_v;
  logic [TW-1:0] mag;
  assign abs_v = smp_data[SW-1] ? -smp_data : smp_data;
  assign mag   = abs_v[SW-1] ? {TW{1'b1}} : abs_v[SW-2 -: TW];

  logic [NCH-1:0][1:0] mode_w;
  logic [NCH-1:0]      over_w, below_w, mwr_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0]    mode_q;
    logic [TW-1:0] up_q, lo_q;
    logic [DW-1:0] dw_q, run_q;
    logic          flg_q;

    wire           sel     = cfg_wr && (cfg_chan == CW'(c));
    wire           mode_wr = sel && (cfg_sel == 2'd0);
    wire           over    = smp_valid && (mag > up_q);
    wire           below   = smp_valid && (mag < lo_q);
    wire [DW-1:0]  run_inc = (&run_q) ? run_q : run_q + DW'(1);
    wire           hit     = below && (run_inc >= dw_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q <= M_OFF;
        up_q   <= '1;
        lo_q   <= '0;
        dw_q   <= '0;
      end else if (sel) begin
        case (cfg_sel)
          2'd0: mode_q <= cfg_data[1:0];
          2'd1: up_q   <= cfg_data[TW-1:0];
          2'd2: lo_q   <= cfg_data[TW-1:0];
          default: dw_q <= cfg_data[DW-1:0];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || mode_wr || mode_q == M_OFF)
        run_q <= '0;
      else if (smp_valid)
        run_q <= below ? run_inc : '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || mode_wr) flg_q <= 1'b0;
      else begin
        case (mode_q)
          M_OVER:  flg_q <= over ? 1'b1 : (clr[c] ? 1'b0 : flg_q);
          M_UNDR:  flg_q <= hit  ? 1'b1 : (clr[c] ? 1'b0 : flg_q);
          M_HYST:  flg_q <= over ? 1'b1 : ((hit || clr[c]) ? 1'b0 : flg_q);
          default: flg_q <= 1'b0;
        endcase
      end
    end

    assign flag[c]    = flg_q;
    assign mode_w[c]  = mode_q;
    assign over_w[c]  = over;
    assign below_w[c] = below;
    assign mwr_w[c]   = mode_wr;
  end
endmodule

// File: rtl/adc_level_watch_chk.sv
module adc_level_watch_chk #(
  parameter int NCH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCH-1:0]      clr,
  input logic [NCH-1:0]      flag,
  input logic [NCH-1:0][1:0] mode_w,
  input logic [NCH-1:0]      over_w,
  input logic [NCH-1:0]      below_w,
  input logic [NCH-1:0]      mwr_w
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_off_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[c] == 2'd0) |-> !flag[c]);

    assert_over_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[c][0] && over_w[c] && !mwr_w[c]) |=> flag[c]);

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_w[c] == 2'd1 || mode_w[c] == 2'd2) && flag[c] && !clr[c] && !mwr_w[c]) |=> flag[c]);

    assert_under_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[c] == 2'd2 && !flag[c] && !below_w[c]) |=> !flag[c]);

    assert_band_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[c] == 2'd3 && flag[c] && !clr[c] && !mwr_w[c] && !below_w[c]) |=> flag[c]);

    assert_mode_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mwr_w[c] |=> !flag[c]);
  end
endmodule

bind adc_level_watch adc_level_watch_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .flag(flag), .mode_w(mode_w),
  .over_w(over_w), .below_w(below_w), .mwr_w(mwr_w)
);

// File: tb/adc_level_watch_tb_top.sv
`timescale 1ns/1ps
module adc_level_watch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [1:0]  clr = '0;
  logic        cfg_wr = 1'b0;
  logic [0:0]  cfg_chan = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic [1:0]  flag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_level_watch dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .clr(clr), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .flag(flag)
  );

  logic [1:0]  m_mode [2];
  logic [13:0] m_up [2];
  logic [13:0] m_lo [2];
  logic [31:0] m_dw [2];
  logic [31:0] m_run [2];
  logic        m_flag [2];

  function automatic logic [13:0] fmag(input logic [15:0] s);
    logic [15:0] a;
    if (s == 16'h8000) return 14'h3fff;
    a = s[15] ? 16'(-s) : s;
    return a[14:1];
  endfunction

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_mode[c] = 0; m_up[c] = 14'h3fff; m_lo[c] = 0; m_dw[c] = 0;
      m_run[c] = 0; m_flag[c] = 0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      logic [13:0] mg;
      logic ov, bl, hit;
      logic [31:0] inc;
      mg  = fmag(smp_data);
      ov  = smp_valid && (mg > m_up[c]);
      bl  = smp_valid && (mg < m_lo[c]);
      inc = (m_run[c] == 32'hffff_ffff) ? m_run[c] : m_run[c] + 1;
      hit = bl && (inc >= m_dw[c]);
      if (cfg_wr && cfg_chan == c[0] && cfg_sel == 0) begin
        m_flag[c] = 0; m_run[c] = 0; m_mode[c] = cfg_data[1:0];
      end else begin
        case (m_mode[c])
          2'd0: m_flag[c] = 0;
          2'd1: m_flag[c] = ov ? 1'b1 : (clr[c] ? 1'b0 : m_flag[c]);
          2'd2: m_flag[c] = hit ? 1'b1 : (clr[c] ? 1'b0 : m_flag[c]);
          default: m_flag[c] = ov ? 1'b1 : ((hit || clr[c]) ? 1'b0 : m_flag[c]);
        endcase
        if (m_mode[c] == 0) m_run[c] = 0;
        else if (smp_valid) m_run[c] = bl ? inc : 0;
        if (cfg_wr && cfg_chan == c[0]) begin
          case (cfg_sel)
            2'd1: m_up[c] = cfg_data[13:0];
            2'd2: m_lo[c] = cfg_data[13:0];
            2'd3: m_dw[c] = cfg_data;
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic cyc(input logic v, input logic [15:0] s, input logic [1:0] cl,
                     input logic w, input logic ch, input logic [1:0] sl,
                     input logic [31:0] d, input string tag);
    smp_valid = v; smp_data = s; clr = cl;
    cfg_wr = w; cfg_chan = ch; cfg_sel = sl; cfg_data = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    smp_valid = 0; clr = 0; cfg_wr = 0;
    for (int c = 0; c < 2; c++) begin
      checks++;
      if (flag[c] !== m_flag[c]) begin
        fails++;
        $display("FAIL %s ch%0d: flag=%0b expected %0b", tag, c, flag[c], m_flag[c]);
      end
    end
  endtask

  task automatic expect_flag(input int c, input logic e, input string tag);
    checks++;
    if (flag[c] !== e) begin
      fails++;
      $display("FAIL %s ch%0d: flag=%0b expected %0b", tag, c, flag[c], e);
    end
  endtask

  task automatic wcfg(input logic ch, input logic [1:0] sl, input logic [31:0] d);
    cyc(0, 0, 0, 1, ch, sl, d, "R10");
  endtask

  task automatic smp(input logic [15:0] s, input string tag);
    cyc(1, s, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic idle(input logic [1:0] cl, input string tag);
    cyc(0, 0, cl, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: cycles=200000 expected completion");
    summary();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2417);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_flag(0, 0, "R2 reset");
    expect_flag(1, 0, "R2 reset");

    // latch-high, magnitude corners
    wcfg(0, 0, 1); wcfg(0, 1, 16382);
    smp(16'h8000, "R1");            expect_flag(0, 1, "R1 min code");
    idle(2'b01, "R3");              expect_flag(0, 0, "R3 clear");
    smp(16'h7fff, "R1");            expect_flag(0, 1, "R1 max code");
    idle(2'b01, "R3");
    wcfg(0, 1, 16383);
    smp(16'h8000, "R1");            expect_flag(0, 0, "R1 saturate equal");
    smp(16'd32766, "R3");           expect_flag(0, 0, "R3 strict compare");
    wcfg(0, 1, 100);
    smp(16'd202, "R3");             expect_flag(0, 1, "R3 set");
    smp(16'd0, "R3");               expect_flag(0, 1, "R3 hold");
    cyc(1, 16'd300, 2'b01, 0, 0, 0, 0, "R7"); expect_flag(0, 1, "R7 set wins");
    cyc(1, 16'd0, 2'b01, 0, 0, 0, 0, "R7");   expect_flag(0, 0, "R7 clear");
    smp(16'hfffe, "R1");            expect_flag(0, 0, "R1 -2 gives 1");
    expect_flag(1, 0, "R9 other channel");

    // latch-low with dwell 5
    wcfg(1, 0, 2); wcfg(1, 2, 100); wcfg(1, 3, 5);
    for (int i = 0; i < 4; i++) smp(16'd20, "R6");
    smp(16'd400, "R6");             expect_flag(1, 0, "R6 restart");
    for (int i = 0; i < 4; i++) smp(16'hffec, "R6");
    expect_flag(1, 0, "R6 four of five");
    smp(16'd20, "R4");              expect_flag(1, 1, "R4 dwell met");
    smp(16'd9000, "R4");            expect_flag(1, 1, "R4 hold above");
    idle(2'b10, "R4");              expect_flag(1, 0, "R4 clear");
    smp(16'd20, "R6"); smp(16'd20, "R6");
    idle(0, "R6"); idle(0, "R6"); idle(0, "R6");
    smp(16'd20, "R6"); smp(16'd20, "R6"); expect_flag(1, 0, "R6 idle no advance");
    smp(16'd20, "R6");              expect_flag(1, 1, "R6 idle no restart");
    idle(2'b10, "R7");
    wcfg(1, 3, 0);
    smp(16'd600, "R6");             expect_flag(1, 0, "R6 at-or-above");
    smp(16'd20, "R6");              expect_flag(1, 1, "R6 dwell zero");
    wcfg(1, 0, 2);                  expect_flag(1, 0, "R8 mode rewrite");
    cyc(1, 16'd20, 0, 1, 1, 0, 2, "R8"); expect_flag(1, 0, "R8 beats sample");
    smp(16'd20, "R8");              expect_flag(1, 1, "R8 next sample");

    // band mode
    wcfg(0, 0, 3); wcfg(0, 1, 1000); wcfg(0, 2, 200); wcfg(0, 3, 3);
    smp(16'd3000, "R5");            expect_flag(0, 1, "R5 set");
    smp(16'd100, "R5"); smp(16'd100, "R5");
    smp(16'd1000, "R5");            expect_flag(0, 1, "R5 mid band");
    smp(16'd100, "R5"); smp(16'd100, "R5"); expect_flag(0, 1, "R5 run restarted");
    smp(16'd100, "R5");             expect_flag(0, 0, "R5 drop");
    smp(16'hf000, "R5");            expect_flag(0, 1, "R5 negative set");
    idle(2'b01, "R7");              expect_flag(0, 0, "R7 band clear");
    expect_flag(1, 1, "R9 other channel held");

    // disabled
    wcfg(0, 0, 0);
    smp(16'd30000, "R2");           expect_flag(0, 0, "R2 off");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic v, w, ch;
      logic [15:0] s;
      logic [1:0] cl, sl;
      logic [31:0] d;
      v  = ($urandom % 10) < 8;
      s  = (($urandom % 20) == 0) ? 16'($urandom) : 16'(($urandom % 8000) - 4000);
      cl = 2'(($urandom % 10) == 0 ? 1 : 0) | 2'(($urandom % 10) == 0 ? 2 : 0);
      w  = ($urandom % 12) == 0;
      ch = 1'($urandom);
      sl = 2'($urandom);
      case (sl)
        2'd0: d = 32'($urandom % 4);
        2'd3: d = 32'($urandom % 9);
        default: d = 32'($urandom % 2000);
      endcase
      cyc(v, s, cl, w, ch, sl, d, $sformatf("%s/R9 random", mtag(m_mode[n % 2])));
    end
    summary();
  end
endmodule